// File: doc/BRIEF.md
# Data-Processing ALU with Flag Update

This block is the execute stage of a 32-bit integer core: a purely combinational unit that performs the sixteen data-processing operations. Each operation takes a first operand read from a register and a second operand that has already passed through the barrel shifter. The block returns the result and a write-enable for the destination register. It also returns the next value of the four condition flags: negative, zero, carry and overflow. When the instruction asks for it, the block raises a request to copy the saved status register back into the current one.

The caller supplies a 4-bit operation code and a set-flags bit, plus the destination register index, both operands and the shifter's carry-out. It also supplies the present flags and an indication of whether the current processor mode owns a saved status register. Operand generation, the register file and mode handling belong to other blocks. The width of the datapath, the width of a register index and the index of the program counter are parameters. A second parameter chooses how overflow is detected.

Top module: `dp_alu`

## Requirements
- R1: The operation code selects the function as follows. 0 is AND, 1 is exclusive-OR, 2 is Rn-minus-operand, 3 is operand-minus-Rn, 4 is add, 5 is add-with-carry, 6 is subtract-with-carry, 7 is reverse-subtract-with-carry, 8 is test (AND), 9 is test-equal (exclusive-OR), 10 (0xA) is compare (subtract), 11 (0xB) is compare-negative (add), 12 (0xC) is OR, 13 (0xD) is move operand, 14 (0xE) is Rn AND NOT operand, and 15 (0xF) is move NOT operand. The logical codes 0, 1, 8, 9 and 12 to 15 produce that bitwise result.
- R2: `wr_en` is 0 for the codes 8 to 11 and 1 for every other code.
- R3: For codes other than 8 to 11, `flags_out` equals `flags_in` whenever `set_flags` is 0.
- R4: Flags are packed as bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V. When a logical operation updates the flags, N is result bit 31 and Z is 1 exactly when the result is zero. C copies `shop_carry` and V keeps `flags_in[0]`.
- R5: Codes 4, 5 and 11 add Rn and the operand, and code 5 also adds the incoming C flag. The addition is carried out in 33 bits. C is the carry out of bit 31. V is 1 when the result is outside the signed 32-bit range.
- R6: Codes 2 and 10 compute Rn minus the operand. Code 3 computes the operand minus Rn. Code 6 computes Rn minus the operand minus (1 - C). Code 7 computes the operand minus Rn minus (1 - C). For all of these, C is 1 exactly when no borrow occurs, and V is 1 when the signed difference is outside the signed 32-bit range.
- R7: Codes 8 to 11 update N, Z, C and V whatever the value of `set_flags`.
- R8: For a code other than 8 to 11, if `set_flags` is 1 and `dest_idx` is 15, the flags are not updated (`flags_out` = `flags_in`). In that case `restore_req` equals `mode_has_saved`.
- R9: In every other case `restore_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation code (R1 encoding) |
| set_flags | input | 1 | Request to update the flags |
| dest_idx | input | 4 | Destination register index |
| mode_has_saved | input | 1 | Current mode owns a saved status register |
| rn_val | input | 32 | First operand |
| shop_val | input | 32 | Shifted second operand |
| shop_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Present N,Z,C,V |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next N,Z,C,V |
| restore_req | output | 1 | Copy saved status into current status |

## Verification
The block holds no state, so an internal fault shows at the ports in the same evaluation as the stimulus that exercises it. A wrong carry-in selection, a swapped operand order or a misrouted flag source appears at once in `result` or `flags_out`. It only appears, though, for operand values that reach the affected bit. For that reason the sweep crosses every code, flag input, set-flags value, destination and mode bit with the signed and unsigned boundary operands 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. Pseudo-random operands then cover the interior of the range.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } dp_op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   // Codes 8..11 only update flags.
   function automatic logic op_is_test(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

   function automatic logic op_is_logic(input logic [3:0] op);
      return (op == OP_AND) || (op == OP_EOR) || (op == OP_TST) ||
             (op == OP_TEQ) || (op[3:2] == 2'b11);
   endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
   import dp_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] rn_val,
   input  logic [WIDTH-1:0] shop_val,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      case (op)
         OP_AND, OP_TST: res = rn_val & shop_val;
         OP_EOR, OP_TEQ: res = rn_val ^ shop_val;
         OP_ORR:         res = rn_val | shop_val;
         OP_MOV:         res = shop_val;
         OP_BIC:         res = rn_val & ~shop_val;
         OP_MVN:         res = ~shop_val;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
   import dp_alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int OVF_STYLE = 0   // 0: sign comparison, 1: carry-in xor carry-out of MSB
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] rn_val,
   input  logic [WIDTH-1:0] shop_val,
   input  logic             c_in,
   output logic [WIDTH-1:0] res,
   output logic             c_out,
   output logic             v_out
);

   localparam int MSB = WIDTH - 1;

   logic             swap_ops;
   logic             is_sub;
   logic             carry_in;
   logic [WIDTH-1:0] opa;
   logic [WIDTH-1:0] opb_raw;
   logic [WIDTH-1:0] opb;
   logic [WIDTH:0]   sum;

   always_comb begin
      swap_ops = (op == OP_RSB) || (op == OP_RSC);
      is_sub   = (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
                 (op == OP_RSC) || (op == OP_CMP);
      case (op)
         OP_ADC, OP_SBC, OP_RSC:  carry_in = c_in;
         OP_SUB, OP_RSB, OP_CMP:  carry_in = 1'b1;
         default:                 carry_in = 1'b0;
      endcase
      opa     = swap_ops ? shop_val : rn_val;
      opb_raw = swap_ops ? rn_val   : shop_val;
      opb     = is_sub ? ~opb_raw : opb_raw;
      // Three-input sum in WIDTH+1 bits: a carry-in can itself carry out.
      sum     = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
      res     = sum[MSB:0];
      c_out   = sum[WIDTH];
   end

   generate
      if (OVF_STYLE == 0) begin : g_ovf_sign
         assign v_out = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
      end else begin : g_ovf_carry
         logic [MSB:0] low_sum;
         assign low_sum = {1'b0, opa[MSB-1:0]} + {1'b0, opb[MSB-1:0]} +
                          {{MSB{1'b0}}, carry_in};
         assign v_out   = low_sum[MSB] ^ sum[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dp_alu_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int PC_INDEX = 15
) (
   input  logic [3:0]       op,
   input  logic             set_flags,
   input  logic [IDX_W-1:0] dest_idx,
   input  logic             mode_has_saved,
   input  logic [3:0]       flags_in,
   input  logic             res_msb,
   input  logic             res_zero,
   input  logic             logic_carry,
   input  logic             arith_carry,
   input  logic             arith_ovf,
   output logic [3:0]       flags_out,
   output logic             wr_en,
   output logic             restore_req
);

   localparam logic [IDX_W-1:0] PC_IDX = PC_INDEX[IDX_W-1:0];

   logic       is_test;
   logic       is_logic;
   logic       pc_restore;
   logic       do_update;
   logic [3:0] computed;

   always_comb begin
      is_test    = op_is_test(op);
      is_logic   = op_is_logic(op);
      pc_restore = set_flags && (dest_idx == PC_IDX) && !is_test;
      do_update  = (set_flags || is_test) && !pc_restore;

      computed[FLAG_N] = res_msb;
      computed[FLAG_Z] = res_zero;
      computed[FLAG_C] = is_logic ? logic_carry : arith_carry;
      computed[FLAG_V] = is_logic ? flags_in[FLAG_V] : arith_ovf;

      flags_out   = do_update ? computed : flags_in;
      wr_en       = !is_test;
      restore_req = pc_restore && mode_has_saved;
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int IDX_W     = 4,
   parameter int PC_INDEX  = 15,
   parameter int OVF_STYLE = 0
) (
   input  logic [3:0]       op_code,
   input  logic             set_flags,
   input  logic [IDX_W-1:0] dest_idx,
   input  logic             mode_has_saved,
   input  logic [WIDTH-1:0] rn_val,
   input  logic [WIDTH-1:0] shop_val,
   input  logic             shop_carry,
   input  logic [3:0]       flags_in,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic [3:0]       flags_out,
   output logic             restore_req
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dp_alu: WIDTH must be at least 2");
      end
      if (PC_INDEX >= (1 << IDX_W)) begin : g_bad_pc
         $error("dp_alu: PC_INDEX does not fit in IDX_W bits");
      end
      if (OVF_STYLE != 0 && OVF_STYLE != 1) begin : g_bad_ovf
         $error("dp_alu: OVF_STYLE must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] logic_res;
   logic [WIDTH-1:0] arith_res;
   logic             arith_c;
   logic             arith_v;

   dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op       (op_code),
      .rn_val   (rn_val),
      .shop_val (shop_val),
      .res      (logic_res)
   );

   dp_alu_arith #(.WIDTH(WIDTH), .OVF_STYLE(OVF_STYLE)) u_arith (
      .op       (op_code),
      .rn_val   (rn_val),
      .shop_val (shop_val),
      .c_in     (flags_in[FLAG_C]),
      .res      (arith_res),
      .c_out    (arith_c),
      .v_out    (arith_v)
   );

   assign result = op_is_logic(op_code) ? logic_res : arith_res;

   dp_alu_flags #(.IDX_W(IDX_W), .PC_INDEX(PC_INDEX)) u_flags (
      .op             (op_code),
      .set_flags      (set_flags),
      .dest_idx       (dest_idx),
      .mode_has_saved (mode_has_saved),
      .flags_in       (flags_in),
      .res_msb        (result[WIDTH-1]),
      .res_zero       (result == '0),
      .logic_carry    (shop_carry),
      .arith_carry    (arith_c),
      .arith_ovf      (arith_v),
      .flags_out      (flags_out),
      .wr_en          (wr_en),
      .restore_req    (restore_req)
   );

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
   import dp_alu_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int IDX_W    = 4,
   parameter int PC_INDEX = 15
) (
   input logic [3:0]       op_code,
   input logic             set_flags,
   input logic [IDX_W-1:0] dest_idx,
   input logic             mode_has_saved,
   input logic             shop_carry,
   input logic [3:0]       flags_in,
   input logic [WIDTH-1:0] result,
   input logic             wr_en,
   input logic [3:0]       flags_out,
   input logic             restore_req
);

   logic tst_op;
   logic pc_case;
   logic upd;

   always_comb begin
      tst_op  = (op_code >= 4'h8) && (op_code <= 4'hB);
      pc_case = set_flags && (dest_idx == PC_INDEX[IDX_W-1:0]) && !tst_op;
      upd     = (set_flags || tst_op) && !pc_case;

      a_r2_test_no_write: assert (!(tst_op && wr_en))
         else $error("R2: compare/test op wrote a result");
      a_r3_flags_hold: assert (!(!set_flags && !tst_op) || flags_out == flags_in)
         else $error("R3: flags changed with set_flags low");
      a_r4_logic_v_kept: assert (!(upd && op_is_logic(op_code)) ||
                                 (flags_out[FLAG_V] == flags_in[FLAG_V] &&
                                  flags_out[FLAG_C] == shop_carry))
         else $error("R4: logical op disturbed V or missed shifter carry");
      a_r4_nz_track: assert (!upd || (flags_out[FLAG_N] == result[WIDTH-1] &&
                                      flags_out[FLAG_Z] == (result == '0)))
         else $error("R4: N/Z do not follow result");
      a_r8_pc_restore: assert (!pc_case || (flags_out == flags_in &&
                                            restore_req == mode_has_saved))
         else $error("R8: PC write with S set mishandled");
      a_r9_no_restore: assert (pc_case || !restore_req)
         else $error("R9: spurious restore request");
   end

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W), .PC_INDEX(PC_INDEX)) u_chk (
   .op_code        (op_code),
   .set_flags      (set_flags),
   .dest_idx       (dest_idx),
   .mode_has_saved (mode_has_saved),
   .shop_carry     (shop_carry),
   .flags_in       (flags_in),
   .result         (result),
   .wr_en          (wr_en),
   .flags_out      (flags_out),
   .restore_req    (restore_req)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_code = '0;
   logic        set_flags = 1'b0;
   logic [3:0]  dest_idx = '0;
   logic        mode_has_saved = 1'b0;
   logic [31:0] rn_val = '0;
   logic [31:0] shop_val = '0;
   logic        shop_carry = 1'b0;
   logic [3:0]  flags_in = '0;
   logic [31:0] result;
   logic        wr_en;
   logic [3:0]  flags_out;
   logic        restore_req;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dp_alu u_dut (
      .op_code(op_code), .set_flags(set_flags), .dest_idx(dest_idx),
      .mode_has_saved(mode_has_saved), .rn_val(rn_val), .shop_val(shop_val),
      .shop_carry(shop_carry), .flags_in(flags_in), .result(result),
      .wr_en(wr_en), .flags_out(flags_out), .restore_req(restore_req)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s op=%0h s=%0b d=%0d rn=%h sh=%h fi=%b actual=%h expected=%h",
                  req, op_code, set_flags, dest_idx, rn_val, shop_val, flags_in, act, exp);
      end
   endtask

   // Reference model written from the requirements.
   task automatic model(output logic [31:0] r, output logic we, output logic [3:0] fo,
                        output logic rr, output string rtag, output string ftag);
      logic [31:0] x, y;
      longint unsigned ux, uy, us;
      longint sx, sy, sr;
      int k;
      logic c, v, tst, pcr, upd;
      c = shop_carry; v = flags_in[0];
      rtag = "R1"; ftag = "R4";
      case (op_code)
         4'h0, 4'h8: r = rn_val & shop_val;
         4'h1, 4'h9: r = rn_val ^ shop_val;
         4'hC:       r = rn_val | shop_val;
         4'hD:       r = shop_val;
         4'hE:       r = rn_val & ~shop_val;
         4'hF:       r = ~shop_val;
         4'h4, 4'h5, 4'hB: begin
            rtag = "R5"; ftag = "R5";
            k  = (op_code == 4'h5) ? int'(flags_in[1]) : 0;
            ux = longint'(rn_val); uy = longint'(shop_val);
            us = ux + uy + longint'(k);
            r  = us[31:0]; c = us[32];
            sx = longint'($signed(rn_val)); sy = longint'($signed(shop_val));
            sr = sx + sy + longint'(k);
            v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
         end
         default: begin
            rtag = "R6"; ftag = "R6";
            if (op_code == 4'h3 || op_code == 4'h7) begin x = shop_val; y = rn_val; end
            else begin x = rn_val; y = shop_val; end
            k  = (op_code == 4'h6 || op_code == 4'h7) ? int'(!flags_in[1]) : 0;
            ux = longint'(x); uy = longint'(y);
            c  = ux >= (uy + longint'(k));
            r  = x - y - 32'(k);
            sx = longint'($signed(x)); sy = longint'($signed(y));
            sr = sx - sy - longint'(k);
            v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
         end
      endcase
      tst = (op_code >= 4'h8) && (op_code <= 4'hB);
      we  = !tst;
      pcr = set_flags && dest_idx == 4'd15 && !tst;
      upd = (set_flags || tst) && !pcr;
      fo  = upd ? {r[31], r == 32'd0, c, v} : flags_in;
      rr  = pcr && mode_has_saved;
      if (pcr) ftag = "R8";
      else if (tst) ftag = {"R7/", ftag};
      else if (!set_flags) ftag = "R3";
   endtask

   task automatic apply_and_check();
      logic [31:0] er; logic ew; logic [3:0] ef; logic err; string rt, ft;
      #2;
      model(er, ew, ef, err, rt, ft);
      chk(result == er, rt, result, er);
      chk(wr_en == ew, "R2", 32'(wr_en), 32'(ew));
      chk(flags_out == ef, ft, 32'(flags_out), 32'(ef));
      chk(restore_req == err, err ? "R8" : "R9", 32'(restore_req), 32'(err));
   endtask

   logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
   logic [31:0] lfsr = 32'h1234_5678;

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
      return t;
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Idle state: all-zero inputs give AND of zeros with no flag change.
      @(negedge clk);
      #2;
      chk(result == 32'h0 && wr_en && flags_out == 4'h0 && !restore_req,
          "R1 idle", {result[27:0], wr_en, flags_out[0], restore_req, 1'b0}, 32'h8);

      // Sweep over every code, control bit and boundary operand pair.
      for (int o = 0; o < 16; o++)
         for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++)
               for (int m = 0; m < 2; m++)
                  for (int f = 0; f < 16; f++)
                     for (int a = 0; a < 5; a++)
                        for (int b = 0; b < 5; b++)
                           for (int sc = 0; sc < 2; sc++) begin
                              @(negedge clk);
                              op_code = 4'(o); set_flags = s[0];
                              dest_idx = d[0] ? 4'd15 : 4'd3;
                              mode_has_saved = m[0]; flags_in = 4'(f);
                              rn_val = corner[a]; shop_val = corner[b];
                              shop_carry = sc[0];
                              apply_and_check();
                           end

      // Pseudo-random interior operands.
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         lfsr = nxt(lfsr); rn_val = lfsr;
         lfsr = nxt(lfsr); shop_val = lfsr;
         lfsr = nxt(lfsr);
         op_code = lfsr[3:0]; set_flags = lfsr[4]; dest_idx = lfsr[8:5];
         mode_has_saved = lfsr[9]; shop_carry = lfsr[10]; flags_in = lfsr[14:11];
         apply_and_check();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule